// File: doc/BRIEF.md
# Legacy Memory Region Address Router

This block sits between the host access path and the memory controller. For every host access it decides whether the access is served by DRAM or forwarded to memory-mapped I/O. When DRAM serves it, the block also reports which of the eight DRAM rows holds the address. The decision depends only on the current address and read/write flag, so it is combinational, and it uses configuration state held in a small byte-wide register file.

The configuration is in three parts. Seven attribute bytes give every part of the 768 KB to 1 MB window a two-bit read/write permission. A hole byte can cut one fixed window out of DRAM. Eight row-boundary bytes give the cumulative top of each row in 8 MB units.

The outputs are decided with this priority:
1. An access that falls in an enabled hole goes to I/O.
2. Any other access at or above the last boundary goes to I/O.
3. An access inside the legacy window follows its attribute field.
4. Every other access goes to DRAM.

Internally each access is sorted into one of four classes, which play the part of the decision states: HOLE, BEYOND, LEGACY and PLAIN. Which class is chosen follows the priority order above.

Top module: `lr_addr_router`

## Requirements
- R1: After reset every configuration byte is zero, so every access gives `to_dram`=0 and `row_idx`=0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the byte at `cfg_idx`, and the new value governs routing from the next cycle. The indices are: 0 for the top-area attribute byte, 1 to 6 for the segment attribute bytes, 7 for the hole byte (bits 1:0), and 8 to 15 for the boundary bytes of rows 0 to 7.
- R3: An attribute field is 2 bits: 00 sends everything to I/O, 01 sends reads to DRAM and writes to I/O, 10 sends writes to DRAM and reads to I/O, and 11 sends everything to DRAM.
- R4: The area 0xF0000–0xFFFFF uses bits 5:4 of attribute byte 0, and bits 3:0 of that byte have no effect.
- R5: The area 0xC0000–0xEFFFF is made of twelve 16 KB segments, s = 0..11, in rising address order. Segment s uses attribute byte 1+s/2: bits 1:0 for even s and bits 5:4 for odd s.
- R6: `row_idx` is the lowest n for which the address is below boundary[n] × 8 MB. An empty row, whose boundary equals the one before it, is never selected.
- R7: An access at or above boundary[7] × 8 MB goes to I/O.
- R8: With hole code 01, addresses 0x80000–0x9FFFF go to I/O.
- R9: With hole code 10, addresses 0xF00000–0xFFFFFF go to I/O.
- R10: Hole codes 00 and 11 remove no address from DRAM.
- R11: Whenever `to_dram` is 0, `row_idx` is 0.
- R12: Outside the legacy window and any enabled hole, an address below the last boundary goes to DRAM for both reads and writes, whatever the attribute bytes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_idx | input | 4 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration byte data |
| acc_addr | input | 32 | Host access byte address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| to_dram | output | 1 | 1 when DRAM serves the access, 0 for memory-mapped I/O |
| row_idx | output | 3 | DRAM row holding the access, 0 when not DRAM |

## Verification
Some properties are checked on every clock edge:
- each configuration write lands in the addressed byte;
- an access routed to DRAM is always below the last boundary;
- an enabled hole never reaches DRAM;
- the row index is zero whenever the access goes to I/O;
- the row picked is the first one whose boundary exceeds the address.

The bench scenarios cover what a property cannot express without repeating the decode: the per-segment attribute mapping for reads and writes separately, the reserved bits and the reserved hole code, empty rows, and the exact hole and row edges at their boundary addresses.

// File: rtl/lr_pkg.sv
package lr_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEGS      = 12;
    localparam int ATTR_REGS = SEGS / 2 + 1;

    typedef enum logic [1:0] {
        HOLE_NONE = 2'b00,
        HOLE_LOW  = 2'b01,
        HOLE_HIGH = 2'b10,
        HOLE_RSVD = 2'b11
    } hole_e;

    typedef enum logic [1:0] {
        RG_HOLE,
        RG_BEYOND,
        RG_LEGACY,
        RG_PLAIN
    } region_e;
endpackage

// File: rtl/lr_cfg_regs.sv
module lr_cfg_regs
    import lr_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int CFG_AW = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [CFG_AW-1:0]                     idx,
    input  logic [BYTE_W-1:0]                     wdata,
    output logic [ATTR_REGS-1:0][BYTE_W-1:0]      attr_o,
    output hole_e                                 hole_o,
    output logic [ROWS-1:0][BYTE_W-1:0]           bound_o
);
    localparam int HOLE_IDX   = ATTR_REGS;
    localparam int BOUND_BASE = ATTR_REGS + 1;

    for (genvar k = 0; k < ATTR_REGS; k++) begin : g_attr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                attr_o[k] <= '0;
            else if (we && idx == CFG_AW'(k))
                attr_o[k] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hole_o <= HOLE_NONE;
        else if (we && idx == CFG_AW'(HOLE_IDX))
            hole_o <= hole_e'(wdata[1:0]);
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_bound
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bound_o[r] <= '0;
            else if (we && idx == CFG_AW'(BOUND_BASE + r))
                bound_o[r] <= wdata;
        end
    end

    // R2: a boundary write lands in the addressed row byte
    p_bound_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(idx) >= BOUND_BASE && int'(idx) < BOUND_BASE + ROWS)
        |=> bound_o[int'($past(idx)) - BOUND_BASE] == $past(wdata));

    // R2: an attribute write lands in the addressed attribute byte
    p_attr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(idx) < ATTR_REGS)
        |=> attr_o[int'($past(idx))] == $past(wdata));
endmodule

// File: rtl/lr_attr_decode.sv
module lr_attr_decode
    import lr_pkg::*;
(
    input  logic [ATTR_REGS-1:0][BYTE_W-1:0] attr_i,
    input  logic [3:0]                       seg_i,
    input  logic                             write_i,
    output logic                             permit_o
);
    logic [1:0] field;
    int unsigned reg_sel;

    always_comb begin
        reg_sel = 0;
        field   = '0;
        if (seg_i[3:2] == 2'b11) begin
            field = attr_i[0][5:4];
        end else begin
            reg_sel = 1 + int'(seg_i[3:1]);
            field   = seg_i[0] ? attr_i[reg_sel][5:4] : attr_i[reg_sel][1:0];
        end
        permit_o = write_i ? field[1] : field[0];
    end
endmodule

// File: rtl/lr_row_lookup.sv
module lr_row_lookup
    import lr_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int HI_W  = 9,
    localparam int RW   = $clog2(ROWS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [HI_W-1:0]              addr_hi_i,
    input  logic [ROWS-1:0][BYTE_W-1:0]  bound_i,
    output logic                         below_last_o,
    output logic [RW-1:0]                row_o
);
    logic [ROWS-1:0] below;

    for (genvar r = 0; r < ROWS; r++) begin : g_cmp
        assign below[r] = addr_hi_i < HI_W'(bound_i[r]);
    end

    always_comb begin
        row_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (below[r]) row_o = RW'(r);
        end
    end

    assign below_last_o = below[ROWS-1];

    // R6: the chosen row is one the address lies below
    p_row_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
        below_last_o |-> addr_hi_i < HI_W'(bound_i[row_o]));

    // R6: no lower row also contains the address
    p_row_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (below_last_o && row_o != '0)
        |-> addr_hi_i >= HI_W'(bound_i[row_o - RW'(1)]));
endmodule

// File: rtl/lr_addr_router.sv
module lr_addr_router
    import lr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROWS       = 8,
    parameter int UNIT_SHIFT = 23,
    localparam int CFG_AW    = $clog2(ATTR_REGS + 1 + ROWS),
    localparam int RW        = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_idx,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              to_dram,
    output logic [RW-1:0]     row_idx
);
    localparam int HI_W = ADDR_W - UNIT_SHIFT;

    logic [ATTR_REGS-1:0][BYTE_W-1:0] attr;
    hole_e                            hole;
    logic [ROWS-1:0][BYTE_W-1:0]      bound;
    logic                             permit, below_last, in_hole, in_legacy;
    logic [RW-1:0]                    row_hit;
    region_e                          region;

    lr_cfg_regs #(.ROWS(ROWS), .CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_wdata), .attr_o(attr), .hole_o(hole), .bound_o(bound)
    );

    lr_attr_decode u_attr (
        .attr_i(attr), .seg_i(acc_addr[17:14]), .write_i(acc_write),
        .permit_o(permit)
    );

    lr_row_lookup #(.ROWS(ROWS), .HI_W(HI_W)) u_row (
        .clk(clk), .rst_n(rst_n), .addr_hi_i(acc_addr[ADDR_W-1:UNIT_SHIFT]),
        .bound_i(bound), .below_last_o(below_last), .row_o(row_hit)
    );

    always_comb begin
        unique case (hole)
            HOLE_LOW:  in_hole = (acc_addr >> 17) == ADDR_W'(4);
            HOLE_HIGH: in_hole = (acc_addr >> 20) == ADDR_W'(15);
            default:   in_hole = 1'b0;
        endcase
        in_legacy = (acc_addr >> 18) == ADDR_W'(3);
    end

    always_comb begin
        if (in_hole)          region = RG_HOLE;
        else if (!below_last) region = RG_BEYOND;
        else if (in_legacy)   region = RG_LEGACY;
        else                  region = RG_PLAIN;
    end

    always_comb begin
        to_dram = 1'b0;
        row_idx = '0;
        unique case (region)
            RG_HOLE, RG_BEYOND: to_dram = 1'b0;
            RG_LEGACY:          to_dram = permit;
            RG_PLAIN:           to_dram = 1'b1;
        endcase
        if (to_dram) row_idx = row_hit;
    end

    // R7: DRAM is never chosen at or above the last boundary
    p_dram_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        to_dram |-> acc_addr[ADDR_W-1:UNIT_SHIFT] < HI_W'(bound[ROWS-1]));

    // R8: the low hole never reaches DRAM
    p_low_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hole == HOLE_LOW && acc_addr >= ADDR_W'('h80000) && acc_addr <= ADDR_W'('h9FFFF))
        |-> !to_dram);

    // R9: the high hole never reaches DRAM
    p_high_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hole == HOLE_HIGH && acc_addr >= ADDR_W'('hF00000) && acc_addr <= ADDR_W'('hFFFFFF))
        |-> !to_dram);

    // R11: I/O accesses carry row zero
    p_io_row_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !to_dram |-> row_idx == '0);
endmodule

// File: tb/sim_lr_addr_router.sv
module sim_lr_addr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        to_dram;
    logic [2:0]  row_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lr_addr_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
        .to_dram(to_dram), .row_idx(row_idx)
    );

    task automatic cfg_wr(input logic [3:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [31:0] addr, input logic wr,
                         input logic exp_d, input logic [2:0] exp_row);
        @(negedge clk);
        acc_addr = addr; acc_write = wr;
        #1;
        checks++;
        if (to_dram !== exp_d || row_idx !== exp_row) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0d: got dram=%0d row=%0d, expected dram=%0d row=%0d",
                     tag, addr, wr, to_dram, row_idx, exp_d, exp_row);
        end
    endtask

    task automatic t_reset;
        probe("R1 reset", 32'h0010_0000, 1'b0, 1'b0, 3'd0);
        probe("R1 reset legacy", 32'h000F_0000, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_rows;
        // boundaries in 8 MB units: 2,2,4,4,6,8,8,16 (rows 1,3,6 empty)
        cfg_wr(4'd8, 8'd2);  cfg_wr(4'd9, 8'd2);  cfg_wr(4'd10, 8'd4);
        cfg_wr(4'd11, 8'd4); cfg_wr(4'd12, 8'd6); cfg_wr(4'd13, 8'd8);
        cfg_wr(4'd14, 8'd8); cfg_wr(4'd15, 8'd16);
        probe("R2 R6 row0", 32'h0010_0000, 1'b0, 1'b1, 3'd0);
        probe("R6 row0 top", 32'h00FF_FFFF, 1'b1, 1'b1, 3'd0);
        probe("R6 empty row skipped", 32'h0100_0000, 1'b0, 1'b1, 3'd2);
        probe("R6 row5", 32'h0300_0000, 1'b1, 1'b1, 3'd5);
        probe("R6 row7 top", 32'h07FF_FFFF, 1'b0, 1'b1, 3'd7);
        probe("R7 beyond last", 32'h0800_0000, 1'b0, 1'b0, 3'd0);
        probe("R7 far beyond", 32'hFFFF_0000, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_plain_r12;
        cfg_wr(4'd1, 8'h00);
        probe("R12 below legacy write", 32'h000B_FFFF, 1'b1, 1'b1, 3'd0);
        probe("R12 above legacy read", 32'h0010_0000, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_attr;
        cfg_wr(4'd0, 8'h1F);   // top area 01, low nibble set but ignored
        probe("R4 top read", 32'h000F_8000, 1'b0, 1'b1, 3'd0);
        probe("R4 top write", 32'h000F_8000, 1'b1, 1'b0, 3'd0);
        cfg_wr(4'd1, 8'h32);   // seg0 10, seg1 11
        probe("R3 R5 seg0 read", 32'h000C_0000, 1'b0, 1'b0, 3'd0);
        probe("R3 R5 seg0 write", 32'h000C_3FFF, 1'b1, 1'b1, 3'd0);
        probe("R3 R5 seg1 read", 32'h000C_4000, 1'b0, 1'b1, 3'd0);
        probe("R3 R5 seg1 write", 32'h000C_7FFF, 1'b1, 1'b1, 3'd0);
        cfg_wr(4'd3, 8'h03);   // seg4 11, seg5 00
        probe("R5 seg4 write", 32'h000D_0000, 1'b1, 1'b1, 3'd0);
        probe("R3 R5 seg5 read", 32'h000D_4000, 1'b0, 1'b0, 3'd0);
        cfg_wr(4'd6, 8'h10);   // seg10 00, seg11 01
        probe("R3 R5 seg10 read", 32'h000E_8000, 1'b0, 1'b0, 3'd0);
        probe("R3 R5 seg11 read", 32'h000E_FFFF, 1'b0, 1'b1, 3'd0);
        probe("R3 R5 seg11 write", 32'h000E_C000, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_holes;
        cfg_wr(4'd7, 8'h01);
        probe("R8 low hole start", 32'h0008_0000, 1'b0, 1'b0, 3'd0);
        probe("R8 low hole end", 32'h0009_FFFF, 1'b1, 1'b0, 3'd0);
        probe("R8 below low hole", 32'h0007_FFFF, 1'b0, 1'b1, 3'd0);
        probe("R8 above low hole", 32'h000A_0000, 1'b0, 1'b1, 3'd0);
        cfg_wr(4'd7, 8'h02);
        probe("R9 high hole start", 32'h00F0_0000, 1'b0, 1'b0, 3'd0);
        probe("R9 high hole end", 32'h00FF_FFFF, 1'b1, 1'b0, 3'd0);
        probe("R9 below high hole", 32'h00EF_FFFF, 1'b0, 1'b1, 3'd0);
        probe("R9 low area open", 32'h0008_0000, 1'b0, 1'b1, 3'd0);
        cfg_wr(4'd7, 8'h03);
        probe("R10 reserved low", 32'h0008_0000, 1'b0, 1'b1, 3'd0);
        probe("R10 reserved high", 32'h00F0_0000, 1'b1, 1'b1, 3'd0);
        cfg_wr(4'd7, 8'h00);
        probe("R10 none", 32'h0009_0000, 1'b1, 1'b1, 3'd0);
    endtask

    task automatic t_shrink;
        cfg_wr(4'd15, 8'd8);
        probe("R7 R2 shrunk top", 32'h0400_0000, 1'b0, 1'b0, 3'd0);
        probe("R11 R6 still row5", 32'h03FF_FFFF, 1'b0, 1'b1, 3'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rows();
        t_plain_r12();
        t_attr();
        t_holes();
        t_shrink();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule